// File: doc/BRIEF.md
# Register Rename Unit with Committed Map Recovery

This block renames architectural registers to physical registers for an out-of-order core that keeps every value, speculative or committed, in a single physical register pool. A speculative map gives each architectural register its newest physical tag. A committed map records the tags of retired instructions. A bitmap of unallocated physical registers supplies new destinations and takes back retired ones.

At dispatch, both source registers are looked up in the speculative map in the same cycle. The destination receives the lowest-numbered free physical register, and the speculative map is pointed at that register. At retirement, the committed map entry for the destination takes the retiring tag. The tag it held before goes back to the pool. A misprediction found at the head of the reorder buffer raises the recovery strobe. In one cycle the committed map is then copied into the speculative map, and the pool is rebuilt from the registers that the committed map does not use.

Top module: `rename_unit`

## Requirements
- R1: After reset, both maps hold the identity mapping: architectural register i maps to physical register i, for i from 0 to 7. Physical registers 8 to 15 are free.
- R2: `srcPhysA` and `srcPhysB` show the speculative map entries for `dispSrcA` and `dispSrcB` combinationally, in the same cycle.
- R3: While `dispReady` is high, `destPhys` shows the lowest-numbered free physical register. A dispatch (`dispValid` with `dispReady`) removes that register from the free pool at the clock edge.
- R4: A dispatch writes `destPhys` into the speculative map entry for `dispDest`. Later lookups return the new tag, but the sources of the same dispatch still see the old mapping.
- R5: `dispReady` is low whenever the free pool is empty. A `dispValid` while `dispReady` is low changes no map entry and allocates nothing.
- R6: A retirement (`retValid`) returns to the pool the physical register that the committed map held for `retArch` just before the update. That register can be allocated from the next cycle on.
- R7: A register freed by a retirement in some cycle is never offered on `destPhys` in that same cycle.
- R8: When `recover` is high, `dispReady` is low and any dispatch is ignored. At the clock edge the speculative map becomes a copy of the committed map, including a retirement in the same cycle. The free pool becomes exactly the registers that the committed map does not reference.
- R9: A retirement writes `retPhys` into the committed map entry for `retArch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | Dispatch request |
| dispSrcA | input | 3 | First source architectural register |
| dispSrcB | input | 3 | Second source architectural register |
| dispDest | input | 3 | Destination architectural register |
| dispReady | output | 1 | A dispatch is accepted this cycle |
| srcPhysA | output | 4 | Physical tag of first source |
| srcPhysB | output | 4 | Physical tag of second source |
| destPhys | output | 4 | Physical tag given to the destination |
| retValid | input | 1 | Retirement of one instruction |
| retArch | input | 3 | Retiring destination architectural register |
| retPhys | input | 4 | Retiring destination physical tag |
| recover | input | 1 | Mispredict at reorder buffer head: restore committed state |

## Verification
A retirement can land in the same cycle as a dispatch, or in the same cycle as a recovery. The bench provokes the first case by retiring while the pool is empty and a dispatch is pending. The freed tag must not appear until the following cycle. The second case fires recovery together with a head retirement, and the restored mapping must include that retirement. A reference model in the bench keeps both maps, the pool and an in-order queue of dispatched instructions. It judges every tag and ready value against the rules, across directed phases and a long random mix.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef struct packed {
    logic allocEn;
    logic retireEn;
    logic recoverEn;
  } renameCtrl_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic        dispValid,
  input  logic        retValid,
  input  logic        recover,
  input  logic        freeAny,
  output logic        dispReady,
  output renameCtrl_t ctrl
);
  // Recovery overrides dispatch; an empty pool stalls it.
  always_comb begin
    dispReady      = freeAny && !recover;
    ctrl.allocEn   = dispValid && dispReady;
    ctrl.retireEn  = retValid;
    ctrl.recoverEn = recover;
  end
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  renameCtrl_t                  ctrl,
  input  logic [AW-1:0]                srcA,
  input  logic [AW-1:0]                srcB,
  input  logic [AW-1:0]                dest,
  input  logic [AW-1:0]                retArch,
  input  logic [PW-1:0]                retPhys,
  output logic [PW-1:0]                srcPhysA,
  output logic [PW-1:0]                srcPhysB,
  output logic [PW-1:0]                allocPhys,
  output logic                         freeAny,
  output logic [NUM_ARCH-1:0][PW-1:0]  specMap,
  output logic [NUM_ARCH-1:0][PW-1:0]  retMap,
  output logic [NUM_PHYS-1:0]          freeBits
);
  logic [NUM_ARCH-1:0][PW-1:0] retMapNext;
  logic [NUM_PHYS-1:0]         allocMask, freedMask, refMask, freeNext;

  assign srcPhysA = specMap[srcA];
  assign srcPhysB = specMap[srcB];
  assign freeAny  = |freeBits;

  // Lowest-numbered free register wins.
  always_comb begin
    allocPhys = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--)
      if (freeBits[i]) allocPhys = PW'(i);
  end

  always_comb begin
    retMapNext = retMap;
    if (ctrl.retireEn) retMapNext[retArch] = retPhys;
  end

  always_comb begin
    allocMask = '0;
    freedMask = '0;
    refMask   = '0;
    if (ctrl.allocEn)  allocMask[allocPhys] = 1'b1;
    if (ctrl.retireEn) freedMask[retMap[retArch]] = 1'b1;
    for (int a = 0; a < NUM_ARCH; a++) refMask[retMapNext[a]] = 1'b1;
    freeNext = ctrl.recoverEn ? ~refMask : ((freeBits & ~allocMask) | freedMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        specMap[a] <= PW'(a);
        retMap[a]  <= PW'(a);
      end
      for (int p = 0; p < NUM_PHYS; p++) freeBits[p] <= 1'(p >= NUM_ARCH);
    end else begin
      retMap   <= retMapNext;
      freeBits <= freeNext;
      if (ctrl.recoverEn)    specMap       <= retMapNext;
      else if (ctrl.allocEn) specMap[dest] <= allocPhys;
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dispValid,
  input  logic [AW-1:0] dispSrcA,
  input  logic [AW-1:0] dispSrcB,
  input  logic [AW-1:0] dispDest,
  output logic          dispReady,
  output logic [PW-1:0] srcPhysA,
  output logic [PW-1:0] srcPhysB,
  output logic [PW-1:0] destPhys,
  input  logic          retValid,
  input  logic [AW-1:0] retArch,
  input  logic [PW-1:0] retPhys,
  input  logic          recover
);
  renameCtrl_t                 ctrl;
  logic                        freeAny;
  logic [NUM_ARCH-1:0][PW-1:0] specMapW, retMapW;
  logic [NUM_PHYS-1:0]         freeBitsW;

  rename_ctrl ctrl_i (
    .dispValid(dispValid), .retValid(retValid), .recover(recover),
    .freeAny(freeAny), .dispReady(dispReady), .ctrl(ctrl)
  );

  rename_datapath #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .srcA(dispSrcA), .srcB(dispSrcB), .dest(dispDest),
    .retArch(retArch), .retPhys(retPhys),
    .srcPhysA(srcPhysA), .srcPhysB(srcPhysB), .allocPhys(destPhys),
    .freeAny(freeAny), .specMap(specMapW), .retMap(retMapW), .freeBits(freeBitsW)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        dispValid,
  input logic                        dispReady,
  input logic [PW-1:0]               destPhys,
  input logic                        retValid,
  input logic [AW-1:0]               retArch,
  input logic [PW-1:0]               retPhys,
  input logic                        recover,
  input logic [NUM_ARCH-1:0][PW-1:0] specMapW,
  input logic [NUM_ARCH-1:0][PW-1:0] retMapW,
  input logic [NUM_PHYS-1:0]         freeBitsW
);
  logic [PW-1:0] oldRetPhys;
  assign oldRetPhys = retMapW[retArch];

  assert_offer_is_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    dispReady |-> freeBitsW[destPhys]);
  assert_alloc_taken_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=> !freeBitsW[$past(destPhys)]);
  assert_empty_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (freeBitsW == '0) |-> !dispReady);
  assert_retire_frees_R6: assert property (@(posedge clk) disable iff (!rstN)
    retValid |=> freeBitsW[$past(oldRetPhys)]);
  assert_recover_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    recover |-> !dispReady);
  assert_recover_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> (specMapW == retMapW));
  assert_commit_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    retValid |=> (retMapW[$past(retArch)] == $past(retPhys)));
endmodule

bind rename_unit rename_unit_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) chk_i (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .destPhys(destPhys), .retValid(retValid), .retArch(retArch), .retPhys(retPhys),
  .recover(recover), .specMapW(specMapW), .retMapW(retMapW), .freeBitsW(freeBitsW)
);

// File: tb/rename_unit_tb_top.sv
`timescale 1ns/1ps
module rename_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dispValid = 1'b0, retValid = 1'b0, recover = 1'b0;
  logic [2:0] dispSrcA = '0, dispSrcB = '0, dispDest = '0, retArch = '0;
  logic [3:0] retPhys = '0;
  logic       dispReady;
  logic [3:0] srcPhysA, srcPhysB, destPhys;

  int checks = 0, fails = 0;
  int specM[8], retM[8];
  bit [15:0] freeM;
  int qd[64], qp[64];
  int qh = 0, qt = 0, qn = 0;

  always #2.5 clk = ~clk;

  rename_unit dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispSrcA(dispSrcA),
    .dispSrcB(dispSrcB), .dispDest(dispDest), .dispReady(dispReady),
    .srcPhysA(srcPhysA), .srcPhysB(srcPhysB), .destPhys(destPhys),
    .retValid(retValid), .retArch(retArch), .retPhys(retPhys), .recover(recover)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input bit [15:0] f);
    for (int i = 0; i < 16; i++) if (f[i]) return i;
    return 0;
  endfunction

  // One cycle: drive at the falling edge, judge combinational outputs, update the model.
  task automatic step(input bit dv, input int a, input int b, input int d,
                      input bit rv, input bit rec, input string tag);
    bit doRet, readyExp;
    int ra, rp, oldP, alloc;
    bit [15:0] refd;
    @(negedge clk);
    doRet = rv && (qn > 0);
    ra = qd[qh];
    rp = qp[qh];
    dispValid = dv; dispSrcA = 3'(a); dispSrcB = 3'(b); dispDest = 3'(d);
    retValid = doRet; retArch = 3'(ra); retPhys = 4'(rp); recover = rec;
    #1;
    readyExp = (freeM != 0) && !rec;
    alloc = lowest(freeM);
    check(dispReady == readyExp, tag, "ready", int'(dispReady), int'(readyExp));
    check(int'(srcPhysA) == specM[a], tag, "srcA", int'(srcPhysA), specM[a]);
    check(int'(srcPhysB) == specM[b], tag, "srcB", int'(srcPhysB), specM[b]);
    if (readyExp) check(int'(destPhys) == alloc, tag, "dest", int'(destPhys), alloc);
    oldP = retM[ra];
    if (doRet) begin
      retM[ra] = rp;
      qh = (qh + 1) % 64; qn--;
    end
    if (rec) begin
      refd = '0;
      for (int i = 0; i < 8; i++) begin specM[i] = retM[i]; refd[retM[i]] = 1'b1; end
      freeM = ~refd;
      qh = 0; qt = 0; qn = 0;
    end else begin
      if (dv && readyExp) begin
        specM[d] = alloc; freeM[alloc] = 1'b0;
        qd[qt] = d; qp[qt] = alloc; qt = (qt + 1) % 64; qn++;
      end
      if (doRet) freeM[oldP] = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R3): run did not end, actual 1 expected 0");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin specM[i] = i; retM[i] = i; end
    freeM = 16'hFF00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: identity maps after reset, first offer is 8
    for (int a = 0; a < 8; a++) step(0, a, 7 - a, 0, 0, 0, "R1");
    // R2 R3 R4: fill the pool, each source reading the previous renames
    for (int i = 0; i < 8; i++) step(1, i, (i + 7) % 8, i, 0, 0, "R4");
    // R5: empty pool stalls; the ignored dispatch leaves the map alone
    step(1, 3, 3, 3, 0, 0, "R5");
    for (int a = 0; a < 8; a++) step(0, a, a, 0, 0, 0, "R5");
    // R7: retire into an empty pool while a dispatch waits
    step(1, 0, 1, 2, 1, 0, "R7");
    step(1, 2, 0, 2, 0, 0, "R7");
    // R6: retire and dispatch alternately
    for (int i = 0; i < 10; i++) step(i % 2, i % 8, (i * 3) % 8, (i * 5) % 8, 1, 0, "R6");
    // R8 R9: recovery with a head retirement in the same cycle
    for (int i = 0; i < 4; i++) step(1, i, i + 1, i + 2, 0, 0, "R9");
    step(1, 1, 2, 3, 1, 1, "R8");
    for (int a = 0; a < 8; a++) step(0, a, 7 - a, 0, 0, 0, "R8");
    for (int i = 0; i < 9; i++) step(1, i % 8, 0, (i + 4) % 8, 0, 0, "R8");
    // Random mix of all three functions
    for (int i = 0; i < 3000; i++)
      step(bit'($urandom % 2), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
           bit'(($urandom % 3) == 0), bit'(($urandom % 37) == 0), "R6");
    @(negedge clk);
    dispValid = 1'b0; retValid = 1'b0; recover = 1'b0;
    summary();
  end
endmodule